// File: doc/BRIEF.md
# Accumulator ALU with Decimal Adjust

This block is the 8-bit data arithmetic unit of a small accumulator machine. For each operation it takes an operation code, the accumulator value, the B register value, a second operand and the incoming carry (CY), auxiliary carry (AC) and overflow (OV) flags. It returns the new accumulator, the new B value and the three updated flags. The operations are add, add with carry, subtract with borrow, unsigned multiply, unsigned divide, decimal adjust after a BCD add, increment, decrement, AND, OR, XOR, complement, nibble swap and rotate right.

An operation begins when `start` is high at a rising clock edge while the block is idle. Every operation except multiply and divide finishes at that edge, with `done` high for the next cycle. Multiply and divide run one bit per cycle for eight cycles while `busy` is high. Their final edge writes the results and raises `done`. The results stay on the outputs until the next operation completes. Operand fetch, addressing and register storage belong to the surrounding machine.

Top module: `acc_alu`

## Requirements
- R1: Add (op 0) and add-with-carry (op 1, which also adds `cy_in`) write the 8-bit sum to A. CY is the carry out of bit 7, AC is the carry out of bit 3, and OV is the carry into bit 7 XOR the carry out of bit 7.
- R2: Subtract with borrow (op 2) writes A − operand − `cy_in` to A. CY is the borrow out of bit 7, AC is the borrow out of bit 3, and OV is set when A and the operand differ in sign and the result's sign differs from A's.
- R3: Multiply (op 3) forms the unsigned 16-bit product of A and B. A receives the low byte and B the high byte, so 45h × F5h gives A=09h and B=42h. CY is cleared, OV is set exactly when the product exceeds FFh, and AC is unchanged.
- R4: Divide (op 4) writes the unsigned quotient A / B to A and the remainder to B. CY and OV are cleared and AC is unchanged. When B is zero, OV is set, CY is cleared, and A and B hold fixed values until the next operation.
- R5: Decimal adjust (op 5) first adds 06h when A[3:0] > 9 or AC is set. It then adds 60h when the upper nibble exceeds 9 or CY is set. CY is set if either step carries out of bit 7 and is never cleared. AC and OV are unchanged, so ABh becomes 11h with CY=1.
- R6: Increment (op 6) and decrement (op 7) wrap FFh→00h and 00h→FFh and leave all three flags unchanged.
- R7: AND (op 8), OR (op 9) and XOR (op 10) combine A with the operand and leave all three flags unchanged.
- R8: Complement (op 11) inverts all bits of A. Swap (op 12) exchanges A[7:4] with A[3:0]. Rotate right (op 13) moves each bit down one place, with bit 0 going to bit 7. All three leave the flags unchanged.
- R9: Any operation other than multiply or divide raises `done` in the cycle after the start edge, with `busy` low. Multiply and divide hold `busy` high for 8 cycles and raise `done` in the 9th cycle after the start edge. `start` is ignored while `busy` is high. Outputs change only in cycles where `done` is high.
- R10: After reset, every data and flag output is zero and `busy` and `done` are low. For every operation other than multiply and divide, B passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the operation in `op` (ignored while busy) |
| op | input | 4 | Operation code (0 to 13, see requirements) |
| a_in | input | 8 | Accumulator value |
| b_in | input | 8 | B register value |
| opnd_in | input | 8 | Second operand for add, subtract and logic |
| cy_in | input | 1 | Incoming carry flag |
| ac_in | input | 1 | Incoming auxiliary carry flag |
| ov_in | input | 1 | Incoming overflow flag |
| busy | output | 1 | Multiply or divide in progress |
| done | output | 1 | Results updated at the last edge |
| a_out | output | 8 | New accumulator |
| b_out | output | 8 | New B register |
| cy_out | output | 1 | New carry flag |
| ac_out | output | 1 | New auxiliary carry flag |
| ov_out | output | 1 | New overflow flag |

## Verification
The hardest case to reach from the ports is a `start` request that arrives in the middle of an iterative multiply. This is the only situation in which the block must discard a request. The bench starts a multiply and, on the next cycle, asserts `start` with a different operation. It then confirms that exactly one `done` appears, at the multiply's latency, carrying the product, and that the outputs do not move afterwards. Divide by zero is handled in a similar way: the bench watches the outputs for several idle cycles after the result to confirm that they stay fixed.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
    localparam int DW = 8;
    localparam int NW = DW / 2;
    localparam int CW = $clog2(DW);

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUBB = 4'd2,
        OP_MUL  = 4'd3,
        OP_DIV  = 4'd4,
        OP_DA   = 4'd5,
        OP_INC  = 4'd6,
        OP_DEC  = 4'd7,
        OP_AND  = 4'd8,
        OP_OR   = 4'd9,
        OP_XOR  = 4'd10,
        OP_CPL  = 4'd11,
        OP_SWAP = 4'd12,
        OP_RR   = 4'd13
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic          cy;
        logic          ac;
        logic          ov;
    } alu_res_t;

    function automatic logic is_iter(alu_op_e o);
        return (o == OP_MUL) || (o == OP_DIV);
    endfunction
endpackage

// File: rtl/alu_single.sv
module alu_single
    import acc_alu_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] opnd,
    input  logic          cy,
    input  logic          ac,
    input  logic          ov,
    output alu_res_t      res
);
    localparam logic [DW:0] LO6 = (DW+1)'(6);
    localparam logic [DW:0] HI6 = LO6 << NW;

    logic          cin;
    logic [DW:0]   full;
    logic [NW:0]   lo;
    logic [DW-1:0] sev;
    logic [DW:0]   t;
    logic          c;

    always_comb begin
        res  = '{a: a, b: b, cy: cy, ac: ac, ov: ov};
        cin  = (op == OP_ADDC || op == OP_SUBB) ? cy : 1'b0;
        full = '0;
        lo   = '0;
        sev  = '0;
        t    = {1'b0, a};
        c    = cy;
        case (op)
            OP_ADD, OP_ADDC: begin
                lo   = {1'b0, a[NW-1:0]} + {1'b0, opnd[NW-1:0]} + {{NW{1'b0}}, cin};
                sev  = {1'b0, a[DW-2:0]} + {1'b0, opnd[DW-2:0]} + {{(DW-1){1'b0}}, cin};
                full = {1'b0, a} + {1'b0, opnd} + {{DW{1'b0}}, cin};
                res.a  = full[DW-1:0];
                res.cy = full[DW];
                res.ac = lo[NW];
                res.ov = full[DW] ^ sev[DW-1];
            end
            OP_SUBB: begin
                lo   = {1'b0, a[NW-1:0]} - {1'b0, opnd[NW-1:0]} - {{NW{1'b0}}, cin};
                full = {1'b0, a} - {1'b0, opnd} - {{DW{1'b0}}, cin};
                res.a  = full[DW-1:0];
                res.cy = full[DW];
                res.ac = lo[NW];
                res.ov = (a[DW-1] ^ opnd[DW-1]) & (full[DW-1] ^ a[DW-1]);
            end
            OP_DA: begin
                if (a[NW-1:0] > NW'(9) || ac) t = t + LO6;
                c = c | t[DW];
                if (t[DW-1:NW] > NW'(9) || c) t = {1'b0, t[DW-1:0]} + HI6;
                c = c | t[DW];
                res.a  = t[DW-1:0];
                res.cy = c;
            end
            OP_INC:  res.a = a + DW'(1);
            OP_DEC:  res.a = a - DW'(1);
            OP_AND:  res.a = a & opnd;
            OP_OR:   res.a = a | opnd;
            OP_XOR:  res.a = a ^ opnd;
            OP_CPL:  res.a = ~a;
            OP_SWAP: res.a = {a[NW-1:0], a[DW-1:NW]};
            OP_RR:   res.a = {a[0], a[DW-1:1]};
            default: ;
        endcase
    end
endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv
    import acc_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          go_div,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic          busy,
    output logic          last,
    output logic [DW-1:0] res_lo,
    output logic [DW-1:0] res_hi,
    output logic          ovf
);
    logic [DW-1:0] hi_q, lo_q, dvs_q;
    logic          div_q;
    logic [CW-1:0] cnt_q;

    logic [DW:0]   sum, sh;
    logic          qbit;

    // one bit of shift-add multiply or restoring divide per cycle
    always_comb begin
        sum    = '0;
        sh     = '0;
        qbit   = 1'b0;
        res_hi = hi_q;
        res_lo = lo_q;
        if (div_q) begin
            sh   = {hi_q, lo_q[DW-1]};
            qbit = (sh >= {1'b0, dvs_q});
            res_hi = qbit ? (sh[DW-1:0] - dvs_q) : sh[DW-1:0];
            res_lo = {lo_q[DW-2:0], qbit};
        end else begin
            sum    = {1'b0, hi_q} + (lo_q[0] ? {1'b0, dvs_q} : '0);
            res_hi = sum[DW:1];
            res_lo = {sum[0], lo_q[DW-1:1]};
        end
        last = busy && (cnt_q == CW'(DW-1));
        ovf  = div_q ? (dvs_q == '0) : (res_hi != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            div_q <= 1'b0;
            cnt_q <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
            dvs_q <= '0;
        end else if (go && !busy) begin
            busy  <= 1'b1;
            div_q <= go_div;
            cnt_q <= '0;
            hi_q  <= '0;
            lo_q  <= a;
            dvs_q <= b;
        end else if (busy) begin
            hi_q <= res_hi;
            lo_q <= res_lo;
            if (last) busy <= 1'b0;
            else      cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [3:0] op,
    input  logic [7:0] a_in,
    input  logic [7:0] b_in,
    input  logic [7:0] opnd_in,
    input  logic       cy_in,
    input  logic       ac_in,
    input  logic       ov_in,
    output logic       busy,
    output logic       done,
    output logic [7:0] a_out,
    output logic [7:0] b_out,
    output logic       cy_out,
    output logic       ac_out,
    output logic       ov_out
);
    alu_op_e       op_e;
    alu_res_t      sres;
    logic          accept, go, mlast, movf;
    logic [DW-1:0] mlo, mhi;
    logic          ac_hold;

    assign op_e   = alu_op_e'(op);
    assign accept = start && !busy;
    assign go     = accept && is_iter(op_e);

    alu_single u_single (
        .op(op_e), .a(a_in), .b(b_in), .opnd(opnd_in),
        .cy(cy_in), .ac(ac_in), .ov(ov_in), .res(sres)
    );

    alu_muldiv u_muldiv (
        .clk(clk), .rst(rst), .go(go), .go_div(op_e == OP_DIV),
        .a(a_in), .b(b_in), .busy(busy), .last(mlast),
        .res_lo(mlo), .res_hi(mhi), .ovf(movf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            a_out   <= '0;
            b_out   <= '0;
            cy_out  <= 1'b0;
            ac_out  <= 1'b0;
            ov_out  <= 1'b0;
            ac_hold <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) ac_hold <= ac_in;
            if (mlast) begin
                a_out  <= mlo;
                b_out  <= mhi;
                cy_out <= 1'b0;
                ac_out <= ac_hold;
                ov_out <= movf;
                done   <= 1'b1;
            end else if (accept && !is_iter(op_e)) begin
                a_out  <= sres.a;
                b_out  <= sres.b;
                cy_out <= sres.cy;
                ac_out <= sres.ac;
                ov_out <= sres.ov;
                done   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic [3:0] op,
    input logic [7:0] a_in,
    input logic       cy_in,
    input logic       ac_in,
    input logic       ov_in,
    input logic       busy,
    input logic       done,
    input logic [7:0] a_out,
    input logic [7:0] b_out,
    input logic       cy_out,
    input logic       ac_out,
    input logic       ov_out
);
    // R9
    busy_no_done_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(a_out) && $stable(b_out) && $stable(cy_out)
                   && $stable(ac_out) && $stable(ov_out)));

    // R9
    single_done_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op != 4'd3 && op != 4'd4) |=> (done && !busy));

    // R7
    logic_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op >= 4'd8 && op <= 4'd13) |=>
        (cy_out == $past(cy_in) && ac_out == $past(ac_in) && ov_out == $past(ov_in)));

    // R6
    inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op == 4'd6) |=> (a_out == 8'($past(a_in) + 8'd1)));

    // R3
    iter_cy_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && !cy_out));
endmodule

bind acc_alu acc_alu_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .op(op), .a_in(a_in),
    .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in), .busy(busy), .done(done),
    .a_out(a_out), .b_out(b_out), .cy_out(cy_out), .ac_out(ac_out), .ov_out(ov_out)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
    localparam time CLK_P = 10ns;
    localparam int  NV = 24;
    localparam int  ITER_LAT = 9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] a_in = '0, b_in = '0, opnd_in = '0;
    logic       cy_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
    logic       busy, done, cy_out, ac_out, ov_out;
    logic [7:0] a_out, b_out;

    int total = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    acc_alu dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .a_in(a_in), .b_in(b_in),
        .opnd_in(opnd_in), .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
        .busy(busy), .done(done), .a_out(a_out), .b_out(b_out),
        .cy_out(cy_out), .ac_out(ac_out), .ov_out(ov_out)
    );

    // {op, a, b, opnd, {cy,ac,ov} in, exp a, exp b, exp {cy,ac,ov}}
    localparam logic [49:0] VEC [NV] = '{
        {4'd0,  8'h23, 8'h11, 8'h55, 3'b000, 8'h78, 8'h11, 3'b000},
        {4'd0,  8'h53, 8'h11, 8'h58, 3'b000, 8'hAB, 8'h11, 3'b001},
        {4'd1,  8'hFF, 8'h11, 8'h00, 3'b100, 8'h00, 8'h11, 3'b110},
        {4'd2,  8'h10, 8'h11, 8'h01, 3'b100, 8'h0E, 8'h11, 3'b010},
        {4'd2,  8'h00, 8'h11, 8'h01, 3'b000, 8'hFF, 8'h11, 3'b110},
        {4'd2,  8'h80, 8'h11, 8'h01, 3'b000, 8'h7F, 8'h11, 3'b011},
        {4'd3,  8'h45, 8'hF5, 8'h00, 3'b110, 8'h09, 8'h42, 3'b011},
        {4'd3,  8'h0F, 8'h11, 8'h00, 3'b001, 8'hFF, 8'h00, 3'b000},
        {4'd4,  8'hE8, 8'h1B, 8'h00, 3'b100, 8'h08, 8'h10, 3'b000},
        {4'd4,  8'h07, 8'h09, 8'h00, 3'b011, 8'h00, 8'h07, 3'b010},
        {4'd5,  8'hAB, 8'h11, 8'h00, 3'b000, 8'h11, 8'h11, 3'b100},
        {4'd5,  8'h78, 8'h11, 8'h00, 3'b000, 8'h78, 8'h11, 3'b000},
        {4'd5,  8'h0A, 8'h11, 8'h00, 3'b000, 8'h10, 8'h11, 3'b000},
        {4'd5,  8'h12, 8'h11, 8'h00, 3'b100, 8'h72, 8'h11, 3'b100},
        {4'd5,  8'h99, 8'h11, 8'h00, 3'b011, 8'h9F, 8'h11, 3'b011},
        {4'd6,  8'hFF, 8'h11, 8'h00, 3'b101, 8'h00, 8'h11, 3'b101},
        {4'd7,  8'h00, 8'h11, 8'h00, 3'b010, 8'hFF, 8'h11, 3'b010},
        {4'd8,  8'hF0, 8'h11, 8'h3C, 3'b111, 8'h30, 8'h11, 3'b111},
        {4'd9,  8'hF0, 8'h11, 8'h0F, 3'b000, 8'hFF, 8'h11, 3'b000},
        {4'd10, 8'hFF, 8'h11, 8'h0F, 3'b010, 8'hF0, 8'h11, 3'b010},
        {4'd11, 8'h5A, 8'h11, 8'h00, 3'b100, 8'hA5, 8'h11, 3'b100},
        {4'd12, 8'h3C, 8'h11, 8'h00, 3'b001, 8'hC3, 8'h11, 3'b001},
        {4'd13, 8'h01, 8'h11, 8'h00, 3'b000, 8'h80, 8'h11, 3'b000},
        {4'd13, 8'hB4, 8'h11, 8'h00, 3'b110, 8'h5A, 8'h11, 3'b110}
    };

    function automatic string req_of(logic [3:0] o);
        case (o)
            4'd0, 4'd1:          return "R1";
            4'd2:                return "R2";
            4'd3:                return "R3";
            4'd4:                return "R4";
            4'd5:                return "R5";
            4'd6, 4'd7:          return "R6";
            4'd8, 4'd9, 4'd10:   return "R7";
            default:             return "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] d, input logic [2:0] f, output int lat);
        @(negedge clk);
        op = o; a_in = a; b_in = b; opnd_in = d;
        {cy_in, ac_in, ov_in} = f;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat;
        int dcount;
        logic [7:0] keep_a;

        // R10: reset state
        repeat (3) @(negedge clk);
        check({a_out, b_out, cy_out, ac_out, ov_out, busy, done} == '0, "R10",
              "reset outputs", {a_out, b_out}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done, "R10", "idle after reset", {busy, done}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [49:0] v;
            v = VEC[i];
            run(v[49:46], v[45:38], v[37:30], v[29:22], v[21:19], lat);
            check(a_out == v[18:11], req_of(v[49:46]), "A", a_out, v[18:11]);
            check(b_out == v[10:3],
                  (v[49:46] == 4'd3 || v[49:46] == 4'd4) ? req_of(v[49:46]) : "R10",
                  "B", b_out, v[10:3]);
            check({cy_out, ac_out, ov_out} == v[2:0], req_of(v[49:46]), "flags",
                  {cy_out, ac_out, ov_out}, v[2:0]);
            check(lat == ((v[49:46] == 4'd3 || v[49:46] == 4'd4) ? ITER_LAT : 1),
                  "R9", "latency", lat,
                  (v[49:46] == 4'd3 || v[49:46] == 4'd4) ? ITER_LAT : 1);
        end

        // R4: divide by zero sets OV, clears CY, results stay fixed
        run(4'd4, 8'h07, 8'h00, 8'h00, 3'b100, lat);
        check(ov_out && !cy_out, "R4", "div0 flags", {cy_out, ov_out}, 1);
        keep_a = a_out;
        repeat (4) @(negedge clk);
        check(a_out == keep_a && !done && !busy, "R4", "div0 stable", a_out, keep_a);

        // R9: start while busy is ignored
        @(negedge clk);
        op = 4'd3; a_in = 8'h45; b_in = 8'hF5; {cy_in, ac_in, ov_in} = 3'b000;
        start = 1'b1;
        @(negedge clk);
        op = 4'd0; a_in = 8'h00; opnd_in = 8'h00;
        @(negedge clk);
        start = 1'b0;
        dcount = 0;
        for (int k = 0; k < 20; k++) begin
            if (done) dcount++;
            @(negedge clk);
        end
        check(dcount == 1, "R9", "single done", dcount, 1);
        check(a_out == 8'h09 && b_out == 8'h42, "R9", "mul kept", {a_out, b_out}, 16'h0942);

        // R9: outputs hold while idle with no start
        keep_a = a_out;
        repeat (3) @(negedge clk);
        check(a_out == keep_a && !done, "R9", "idle hold", a_out, keep_a);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule